// File: doc/BRIEF.md
# Edge-Sensed External Interrupt Channel

This block serves one external interrupt pin. A sense bit picks the active edge: falling when the bit is 0, rising when it is 1. The pin itself clocks a capture stage, so an edge is recorded even while the system clock is stopped. The event then crosses into the clock domain through a chain of synchronizer flops. There it sets a sticky pending flag. Software clears the flag by writing 1 to it.

The request to the CPU is the pending flag gated by the channel's mask bit and by the global interrupt enable. The block also has an unsynchronized wake output. It rises as soon as the chosen edge arrives and falls once the clock domain has taken in the event. Sleep control can use it to restart the clock.

Top module: `ext_irq_edge`

## Requirements
- R1: With `sense_rise` = 0, a falling edge on `irq_pin` sets `flag_q` at the third rising clock edge after the pin edge (default `SYNC_LEN` = 2).
- R2: With `sense_rise` = 1, a rising edge on `irq_pin` sets `flag_q` with the same latency.
- R3: A pin edge of the polarity not selected leaves `flag_q` at 0.
- R4: `irq_req` is 1 exactly when `flag_q`, `chan_en` and `gie` are all 1.
- R5: A cycle with `flag_wr` = 1 and `flag_wdata` = 1 clears `flag_q` at that clock edge.
- R6: A cycle with `flag_wr` = 1 and `flag_wdata` = 0 leaves `flag_q` unchanged.
- R7: When a clearing write and a newly synchronized edge fall on the same clock edge, `flag_q` ends up 1.
- R8: Once set, `flag_q` stays 1 until a clearing write, whatever the pin does.
- R9: While `rst_n` is low, `flag_q`, `irq_req` and `wake_async` are 0.
- R10: Flipping `sense_rise` while the pin is static may record an event. Going 0→1 with the pin high, or 1→0 with the pin low, sets `flag_q`.
- R11: `wake_async` rises right after a selected pin edge, with no clock edge needed. It returns to 0 at the clock edge that sets `flag_q`.
- R12: A selected edge in a pin pulse much shorter than one clock period is still recorded in `flag_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| sense_rise | input | 1 | Edge select: 0 falling, 1 rising |
| chan_en | input | 1 | Channel mask bit (1 = enabled) |
| gie | input | 1 | Global interrupt enable |
| flag_wr | input | 1 | Write strobe for the pending flag |
| flag_wdata | input | 1 | Write data; 1 clears the flag |
| flag_q | output | 1 | Pending flag |
| irq_req | output | 1 | Qualified interrupt request |
| wake_async | output | 1 | Unsynchronized wake indication |

## Verification
Two things can meet on one clock edge: a software clear of the pending flag and the arrival of a freshly synchronized pin edge. The bench moves the pin on a falling clock edge, counts the synchronizer stages, and holds a write-one strobe across exactly the rising edge where the event lands. It does this once with the flag already set and once with it clear. Both times it expects the flag to read 1 afterwards. The same edge-counting is used to place plain clears away from events, so the bench can tell a lost clear from a lost edge.

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_pin,
  input  logic sense_rise,
  input  logic chan_en,
  input  logic gie,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag_q,
  output logic irq_req,
  output logic wake_async
);

  logic                trig;
  logic                tog;
  logic [SYNC_LEN-1:0] sync;
  logic                seen;
  logic                hit;

  // selected edge becomes a rising edge of trig
  assign trig = ~(irq_pin ^ sense_rise);

  always_ff @(posedge trig or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      seen <= 1'b0;
    end else begin
      sync <= {sync[SYNC_LEN-2:0], tog};
      seen <= sync[SYNC_LEN-1];
    end
  end

  assign hit = sync[SYNC_LEN-1] ^ seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flag_q <= 1'b0;
    else if (hit)                    flag_q <= 1'b1;
    else if (flag_wr && flag_wdata)  flag_q <= 1'b0;
  end

  assign irq_req    = flag_q & chan_en & gie;
  assign wake_async = tog ^ seen;

endmodule

// File: rtl/ext_irq_edge_chk.sv
module ext_irq_edge_chk (
  input logic clk,
  input logic rst_n,
  input logic chan_en,
  input logic gie,
  input logic flag_wr,
  input logic flag_wdata,
  input logic flag_q,
  input logic irq_req,
  input logic hit
);

  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en || !gie) |-> !irq_req);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wdata && !hit) |=> !flag_q);

  a_r6_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata && flag_q) |=> flag_q);

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_wr) |=> flag_q);

  a_r1_set_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit));

endmodule

bind ext_irq_edge ext_irq_edge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_en    (chan_en),
  .gie        (gie),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .flag_q     (flag_q),
  .irq_req    (irq_req),
  .hit        (hit)
);

// File: tb/test_ext_irq_edge.sv
`timescale 1ns/1ps
module test_ext_irq_edge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_pin = 1'b1, sense_rise = 1'b0, chan_en = 1'b0, gie = 1'b0;
  logic flag_wr = 1'b0, flag_wdata = 1'b0;
  logic flag_q, irq_req, wake_async;
  int checks = 0, errors = 0;

  ext_irq_edge i_ext_irq_edge (.*);

  always #5 clk = ~clk;

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic settle(); // three rising edges, then sample at falling edge
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_wr = 1'b1; flag_wdata = 1'b1;
    @(negedge clk); flag_wr = 1'b0; flag_wdata = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 flag in reset", flag_q, 1'b0);
    chk("R9 req in reset", irq_req, 1'b0);
    chk("R9 wake in reset", wake_async, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sweep: sense x starting pin level x mask x gie
    for (int s = 0; s < 2; s++) begin
      for (int st = 0; st < 2; st++) begin
        logic exp;
        irq_pin = st[0];
        @(negedge clk); sense_rise = s[0];
        settle();
        clear_flag();
        chk("R5 pre-clear", flag_q, 1'b0);
        @(negedge clk); irq_pin = ~st[0];
        exp = (s == 1 && st == 0) || (s == 0 && st == 1);
        #1 chk("R11 wake immediate", wake_async, exp);
        @(negedge clk);
        settle();
        @(posedge clk); @(negedge clk);
        if (s == 0) chk(exp ? "R1 falling sets" : "R3 rising ignored", flag_q, exp);
        else        chk(exp ? "R2 rising sets"  : "R3 falling ignored", flag_q, exp);
        chk("R11 wake dropped", wake_async, 1'b0);
        for (int m = 0; m < 4; m++) begin
          chan_en = m[0]; gie = m[1];
          #1 chk("R4 request gating", irq_req, exp & m[0] & m[1]);
        end
        chan_en = 1'b0; gie = 1'b0;
        irq_pin = st[0]; // opposite edge while flag held
        settle();
        chk("R8 sticky", flag_q, exp | (flag_q & ~exp) | (s == 0 ? st == 0 : st == 1));
      end
    end

    // R6 / R5 on a set flag
    sense_rise = 1'b0; irq_pin = 1'b1; settle(); clear_flag();
    @(negedge clk) irq_pin = 1'b0; settle();
    chk("R1 fall set", flag_q, 1'b1);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    chk("R6 write zero keeps", flag_q, 1'b1);
    clear_flag();
    chk("R5 write one clears", flag_q, 1'b0);

    // R10 sense change glitch, both directions, channel masked
    irq_pin = 1'b1; sense_rise = 1'b0; settle(); clear_flag();
    @(negedge clk) sense_rise = 1'b1; settle();
    chk("R10 sense 0->1 pin high", flag_q, 1'b1);
    chk("R4 masked glitch no req", irq_req, 1'b0);
    irq_pin = 1'b0; settle(); clear_flag();
    @(negedge clk) sense_rise = 1'b0; settle();
    chk("R10 sense 1->0 pin low", flag_q, 1'b1);
    clear_flag();

    // R7 collision: flag clear beforehand, then flag set beforehand
    for (int pre = 0; pre < 2; pre++) begin
      sense_rise = 1'b0; irq_pin = 1'b1; settle(); clear_flag();
      if (pre == 1) begin
        @(negedge clk) irq_pin = 1'b0; settle();
        irq_pin = 1'b1; settle();
      end
      @(negedge clk) irq_pin = 1'b0;
      @(negedge clk);
      @(negedge clk); flag_wr = 1'b1; flag_wdata = 1'b1;
      @(negedge clk); flag_wr = 1'b0; flag_wdata = 1'b0;
      chk("R7 edge wins over clear", flag_q, 1'b1);
      @(negedge clk);
      chk("R7 flag held after collision", flag_q, 1'b1);
    end

    // R12 narrow pulse
    irq_pin = 1'b1; sense_rise = 1'b0; settle(); clear_flag();
    @(negedge clk); #1 irq_pin = 1'b0; #0.5 irq_pin = 1'b1;
    settle(); @(negedge clk);
    chk("R12 narrow pulse caught", flag_q, 1'b1);
    chan_en = 1'b1; gie = 1'b1;
    #1 chk("R4 request live", irq_req, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule